// File: doc/BRIEF.md
# Board Control Register Block

This block is a small set of control and status words for an FPGA evaluation board. It sits on a 32-bit processor bus with a valid/ready handshake and decodes a 64 KiB window. Software uses it to identify the board and to learn the system clock rate. It can also drive a bank of LEDs and read a bank of switches. The switches are synchronised into the clock domain before software sees them.

A reset trigger word lets software ask for a full system reset. The request fires only when the exact magic value 0x0000DEAD is written. Any other value written to that word is dropped. The request leaves the block as a one-cycle pulse, and a separate reset controller acts on it.

Top module: `board_ctl`

## Requirements
- R1: A read at byte offset 0x0 returns the identification word 0x09272011.
- R2: A read at byte offset 0x4 returns the clock frequency in Hz given by parameter CLK_HZ (default 100000000). Bus writes to this offset do not change it.
- R3: Byte offset 0x8 is the LED word. A write there stores all 32 data bits, and they appear on led_out after the accepting clock edge. A later read returns the stored value. No other access changes led_out.
- R4: A read at byte offset 0xC returns sw_in, zero-extended to 32 bits. sw_in passes two synchroniser stages and then the switch register, so a change is visible to a read accepted on the fourth rising edge after it or later. Bus writes to offset 0xC do not change the value read.
- R5: A write of exactly 0x0000DEAD to byte offset 0x10 drives sys_rst_req high for the single cycle after the accepting edge.
- R6: A write of any other value to offset 0x10 leaves sys_rst_req low and changes no other state.
- R7: A read of any word index other than 0..3 returns zero. This includes offset 0x10 and every offset up to 0xFFFC. Writes to read-only or unmapped offsets are ignored, with no error.
- R8: Synchronous active-high reset clears the LED word, both synchroniser stages and the switch register. While rst is high, req_ready, rsp_valid and sys_rst_req are low.
- R9: req_ready is high from the first edge after reset is released. A read accepted on an edge (req_valid and req_ready both high) gives rsp_valid high with its data during the next cycle. rsp_valid is low in every other cycle.
- R10: Only address bits [15:2] select a word. The two low address bits are ignored, so byte addresses 0x3 and 0xB reach the same words as 0x0 and 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| sw_in | input | SW_W (8) | Asynchronous switch levels |
| led_out | output | 32 | LED word |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The checker tests several rules on every cycle:
- A response follows each accepted read one cycle later, and none appears without one.
- Identification, frequency and unmapped reads return their fixed values.
- The reset request follows only a magic write at offset 0x10, and never follows any other value written there.
- The LED word holds unless it is written.

Only the bench scenarios can show the rest:
- The switch synchroniser latency.
- That a read returns the most recently written LED value.
- That writes to read-only words leave them unchanged.
- That the low address bits alias.
- That reset in the middle of a run clears the stored state.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

    localparam int          BUS_W      = 32;
    localparam logic [31:0] BOARD_ID   = 32'h0927_2011;
    localparam logic [31:0] KICK_MAGIC = 32'h0000_DEAD;

    // word indices (byte offset / 4)
    localparam logic [31:0] IDX_ID   = 32'd0;
    localparam logic [31:0] IDX_FREQ = 32'd1;
    localparam logic [31:0] IDX_LED  = 32'd2;
    localparam logic [31:0] IDX_SW   = 32'd3;
    localparam logic [31:0] IDX_KICK = 32'd4;

    typedef enum logic [2:0] {
        SEL_ID,
        SEL_FREQ,
        SEL_LED,
        SEL_SW,
        SEL_KICK,
        SEL_NONE
    } word_sel_e;

    typedef struct packed {
        logic             rd_en;
        logic             wr_en;
        word_sel_e        sel;
        logic [BUS_W-1:0] wdata;
    } bus_op_t;

    function automatic word_sel_e decode_word(input logic [31:0] idx);
        word_sel_e s;
        case (idx)
            IDX_ID:   s = SEL_ID;
            IDX_FREQ: s = SEL_FREQ;
            IDX_LED:  s = SEL_LED;
            IDX_SW:   s = SEL_SW;
            IDX_KICK: s = SEL_KICK;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
    import board_ctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 req_valid,
    input  logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [BUS_W-1:0]     req_wdata,
    output bus_op_t              op
);
    localparam int PAD_W = 32 - ADDR_W;

    logic [ADDR_W-1:0] word_idx;
    logic              accept;

    always_comb begin
        word_idx = req_addr >> 2;
        accept   = req_valid && req_ready;
        op.rd_en = accept && !req_write;
        op.wr_en = accept && req_write;
        op.sel   = decode_word({{PAD_W{1'b0}}, word_idx});
        op.wdata = req_wdata;
    end

endmodule

// File: rtl/board_ctl_sync.sv
module board_ctl_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d_async;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
    import board_ctl_pkg::*;
#(
    parameter int          SW_W   = 8,
    parameter logic [31:0] CLK_HZ = 32'd100_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_op_t          op,
    input  logic [SW_W-1:0]  sw_sync,
    output logic [BUS_W-1:0] led_q,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata,
    output logic             kick_q
);
    localparam int SW_PAD = BUS_W - SW_W;

    logic [SW_W-1:0]  sw_q;
    logic [BUS_W-1:0] rd_mux;
    logic             kick_hit;

    always_comb begin
        case (op.sel)
            SEL_ID:   rd_mux = BOARD_ID;
            SEL_FREQ: rd_mux = CLK_HZ;
            SEL_LED:  rd_mux = led_q;
            SEL_SW:   rd_mux = {{SW_PAD{1'b0}}, sw_q};
            default:  rd_mux = '0;
        endcase
        kick_hit = op.wr_en && (op.sel == SEL_KICK) && (op.wdata == KICK_MAGIC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q     <= '0;
            sw_q      <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            kick_q    <= 1'b0;
        end else begin
            sw_q      <= sw_sync;
            rsp_valid <= op.rd_en;
            kick_q    <= kick_hit;
            if (op.rd_en)                         rsp_rdata <= rd_mux;
            if (op.wr_en && op.sel == SEL_LED)    led_q     <= op.wdata;
        end
    end

endmodule

// File: rtl/board_ctl.sv
module board_ctl
    import board_ctl_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter int          SW_W   = 8,
    parameter logic [31:0] CLK_HZ = 32'd100_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic [SW_W-1:0]   sw_in,
    output logic [31:0]       led_out,
    output logic              sys_rst_req
);
    bus_op_t         op;
    logic [SW_W-1:0] sw_sync;
    logic            ready_q;

    always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b0;
        else     ready_q <= 1'b1;
    end
    assign req_ready = ready_q;

    board_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_ready (ready_q),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .op        (op)
    );

    board_ctl_sync #(.W(SW_W), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (sw_in),
        .q_sync  (sw_sync)
    );

    board_ctl_regs #(.SW_W(SW_W), .CLK_HZ(CLK_HZ)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .sw_sync   (sw_sync),
        .led_q     (led_out),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .kick_q    (sys_rst_req)
    );

endmodule

// File: rtl/board_ctl_chk.sv
module board_ctl_chk
    import board_ctl_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [31:0] CLK_HZ = 32'd100_000_000
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic [31:0]       led_out,
    input logic              sys_rst_req
);
    logic [ADDR_W-3:0] idx;
    logic              acc_rd, acc_wr;

    assign idx    = req_addr[ADDR_W-1:2];
    assign acc_rd = req_valid && req_ready && !req_write;
    assign acc_wr = req_valid && req_ready && req_write;

    AST_READ_RSP: assert property (@(posedge clk) disable iff (rst)
        acc_rd |=> rsp_valid); // R9
    AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(acc_rd)); // R9
    AST_ID_VALUE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(idx) == 0) |-> rsp_rdata == BOARD_ID); // R1
    AST_FREQ_VALUE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(idx) == 1) |-> rsp_rdata == CLK_HZ); // R2
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(idx) >= 4) |-> rsp_rdata == 32'd0); // R7
    AST_KICK_MAGIC: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> $past(acc_wr && idx == 4 && req_wdata == KICK_MAGIC)); // R5
    AST_KICK_OTHER_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && idx == 4 && req_wdata != KICK_MAGIC) |=> !sys_rst_req); // R6
    AST_LED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(acc_wr && idx == 2) |=> $stable(led_out)); // R3

endmodule

bind board_ctl board_ctl_chk #(.ADDR_W(ADDR_W), .CLK_HZ(CLK_HZ)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .led_out     (led_out),
    .sys_rst_req (sys_rst_req)
);

// File: tb/test_board_ctl.sv
module test_board_ctl;
    localparam int          ADDR_W = 16;
    localparam int          SW_W   = 8;
    localparam logic [31:0] HZ     = 32'd100_000_000;
    localparam logic [31:0] ID     = 32'h0927_2011;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr  = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [SW_W-1:0]   sw_in = '0;
    logic [31:0]       led_out;
    logic              sys_rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    board_ctl #(.ADDR_W(ADDR_W), .SW_W(SW_W), .CLK_HZ(HZ)) i_board_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sw_in(sw_in),
        .led_out(led_out), .sys_rst_req(sys_rst_req)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_started = 0;
    bit          m_rdy = 0, m_rsp_v = 0, m_kick = 0;
    logic [31:0] m_led = 0, m_rdata = 0;
    logic [SW_W-1:0] m_swq[$] = '{0, 0, 0}; // [0]=stage1 [1]=stage2 [2]=register
    string       m_tag = "R9";

    always @(posedge clk) begin
        m_started = 1;
        if (rst) begin
            m_rdy = 0; m_rsp_v = 0; m_kick = 0; m_led = 0;
            m_swq = '{0, 0, 0};
        end else begin
            automatic bit acc = m_rdy && req_valid;
            automatic int idx = int'(req_addr) / 4;
            m_rsp_v = acc && !req_write;
            m_kick  = acc && req_write && idx == 4 && req_wdata == 32'h0000_DEAD;
            if (acc && !req_write) begin
                case (idx)
                    0: begin m_rdata = ID;    m_tag = "R1"; end
                    1: begin m_rdata = HZ;    m_tag = "R2"; end
                    2: begin m_rdata = m_led; m_tag = "R3"; end
                    3: begin m_rdata = 32'(m_swq[2]); m_tag = "R4"; end
                    default: begin m_rdata = 0; m_tag = "R7"; end
                endcase
            end
            if (acc && req_write && idx == 2) m_led = req_wdata;
            m_swq = '{sw_in, m_swq[0], m_swq[1]};
            m_rdy = 1;
        end
    end

    always @(negedge clk) begin
        if (m_started && !done) begin
            check(req_ready === m_rdy, "R9 ready", 32'(req_ready), 32'(m_rdy));
            check(rsp_valid === m_rsp_v, "R9 rsp_valid", 32'(rsp_valid), 32'(m_rsp_v));
            check(led_out === m_led, "R3 led_out", led_out, m_led);
            check(sys_rst_req === m_kick, "R5 sys_rst_req", 32'(sys_rst_req), 32'(m_kick));
            if (m_rsp_v)
                check(rsp_rdata === m_rdata, {m_tag, " rdata model"}, rsp_rdata, m_rdata);
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        check(rsp_valid === 1'b1, {tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check(rsp_rdata === exp, tag, rsp_rdata, exp);
    endtask

    initial begin
        sw_in = 8'hA5;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(led_out === 0, "R8 led reset", led_out, 0);
        check(sys_rst_req === 0, "R8 kick reset", 32'(sys_rst_req), 0);
        check(rsp_valid === 0, "R8 rsp reset", 32'(rsp_valid), 0);
        check(req_ready === 0, "R8 ready in reset", 32'(req_ready), 0);
        rst = 0;
        @(negedge clk);
        check(req_ready === 1, "R9 ready after reset", 32'(req_ready), 1);
        // R8: switch register still cleared by reset at this point
        req_valid = 1; req_write = 0; req_addr = 16'h000C;
        @(negedge clk); req_valid = 0;
        check(rsp_rdata === 0, "R8 switch reg cleared", rsp_rdata, 0);
        rd(16'h0000, ID, "R1 id");
        rd(16'h0004, HZ, "R2 freq");
        rd(16'h000C, 32'h0000_00A5, "R4 switches");
        wr(16'h0008, 32'h1234_5678);
        check(led_out === 32'h1234_5678, "R3 led out", led_out, 32'h1234_5678);
        rd(16'h0008, 32'h1234_5678, "R3 led readback");
        wr(16'h000C, 32'hFFFF_FFFF);
        rd(16'h000C, 32'h0000_00A5, "R4 switch write ignored");
        // R4 latency: change then read at once (old), then after 3 edges (new)
        @(negedge clk);
        sw_in = 8'h3C; req_valid = 1; req_write = 0; req_addr = 16'h000C;
        @(negedge clk); req_valid = 0;
        check(rsp_rdata === 32'hA5, "R4 sync latency old", rsp_rdata, 32'hA5);
        @(negedge clk); @(negedge clk);
        rd(16'h000C, 32'h3C, "R4 sync latency new");
        // R7 unmapped and read-only writes
        rd(16'h0010, 0, "R7 kick reads zero");
        rd(16'h0014, 0, "R7 unmapped 0x14");
        rd(16'h0100, 0, "R7 unmapped 0x100");
        rd(16'hFFFC, 0, "R7 unmapped top");
        wr(16'h0000, 32'hDEAD_BEEF);
        wr(16'h0004, 32'h0000_0001);
        wr(16'h0200, 32'h5555_5555);
        rd(16'h0000, ID, "R7 id after write");
        rd(16'h0004, HZ, "R2 freq after write");
        rd(16'h0008, 32'h1234_5678, "R7 led untouched");
        // R6 non-magic values
        wr(16'h0010, 32'h0000_DEAE);
        check(sys_rst_req === 0, "R6 DEAE ignored", 32'(sys_rst_req), 0);
        wr(16'h0010, 32'h0001_DEAD);
        check(sys_rst_req === 0, "R6 1DEAD ignored", 32'(sys_rst_req), 0);
        check(led_out === 32'h1234_5678, "R6 led untouched", led_out, 32'h1234_5678);
        // R5 magic
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 16'h0010; req_wdata = 32'h0000_DEAD;
        @(negedge clk); req_valid = 0; req_write = 0;
        check(sys_rst_req === 1, "R5 kick pulse", 32'(sys_rst_req), 1);
        @(negedge clk);
        check(sys_rst_req === 0, "R5 kick one cycle", 32'(sys_rst_req), 0);
        // R10 low address bits ignored
        rd(16'h0003, ID, "R10 misaligned id");
        wr(16'h000B, 32'hCAFE_0001);
        rd(16'h0009, 32'hCAFE_0001, "R10 misaligned led");
        // R9 back-to-back reads
        @(negedge clk);
        req_valid = 1; req_addr = 16'h0000;
        @(negedge clk);
        req_addr = 16'h0004;
        check(rsp_rdata === ID, "R9 b2b first", rsp_rdata, ID);
        @(negedge clk); req_valid = 0;
        check(rsp_valid === 1 && rsp_rdata === HZ, "R9 b2b second", rsp_rdata, HZ);
        // R8 reset mid-run
        @(negedge clk); rst = 1;
        @(negedge clk);
        check(led_out === 0, "R8 led cleared", led_out, 0);
        rst = 0;
        @(negedge clk);
        rd(16'h000C, 0, "R8 switch reg cleared again");
        repeat (4) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule